// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Frame Sequencer

This block is the digital side of a serial successive-approximation converter. It watches an active-low chip select and a serial clock, already brought into the block's clock domain, and frames one conversion on a serial data line. A parallel sample word stands in for the analog result and is frozen when chip select falls. The block then counts serial clock falling edges. Three auto-zero clocks come first. The decision bits follow, most significant first, each one clock after it is decided. Zeros fill the rest of the frame.

The comparator-power flag covers the auto-zero clocks and the decision clocks. It drops once the fifteenth serial clock falling edge has been seen, and the track flag then comes back even while chip select is still low. Raising chip select early (short cycling) abandons the remaining bits. The serial data line is driven only while a frame is open, and is released when chip select rises. After reset, the first frame is a dummy frame: its data output stays at 0, and the power-on-done flag is set when that frame closes. A `WIDTH` parameter picks a 12-bit or 10-bit result. In the 10-bit build the two slots after the last bit carry 0.

Top module: `sar_serial_seq`

## Requirements
- R1: While no frame is open (after reset, or once chip select has been seen high), sdoDrive is 0, sdoData is 0, trackMode is 1, compPower is 0 and autoZero is 0.
- R2: The sample word is captured on the clock where chip select is first seen low. Later changes of sampleIn during that frame do not change sdoData.
- R3: The frame counts at most 16 serial clock falling edges. Further falling edges while chip select stays low change no output.
- R4: From the chip-select fall until the third serial clock falling edge, autoZero and compPower are 1. Until the fourth falling edge, sdoData is 0 while sdoDrive is 1.
- R5: After falling edge k, with k from 4 to 15, sdoData carries sample bit 15-k: bit 11 (the MSB) after edge 4, down to bit 0 after edge 15.
- R6: From the fifteenth falling edge on, compPower is 0 and trackMode is 1 while chip select stays low.
- R7: After the sixteenth falling edge, sdoData is 0 and sdoDrive stays 1 until chip select rises.
- R8: If chip select rises before 16 falling edges, the frame ends at once and the state of R1 returns.
- R9: powerOnDone is 0 after reset. It becomes 1 when the first frame ends and then stays 1. During that first frame, sdoData stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; csN and sclk are sampled on its rising edge |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| csN | input | 1 | Active-low chip select, synchronous to clk |
| sclk | input | 1 | Serial clock, idle high, synchronous to clk |
| sampleIn | input | WIDTH | Result word standing in for the analog conversion |
| sdoData | output | 1 | Serial data value (0 when not driven) |
| sdoDrive | output | 1 | Output enable of the serial data pad; 0 means high impedance |
| compPower | output | 1 | Comparator powered |
| autoZero | output | 1 | Comparator auto-zero phase |
| trackMode | output | 1 | Sampling capacitors tracking the input |
| powerOnDone | output | 1 | Dummy frame after reset has completed |

## Verification
Every output is a function of registers that are loaded on the clk rising edge that first sees a csN or sclk change. Each result is therefore due exactly one clk cycle after the input is driven. The driver stamps every expected item with that due cycle, and the monitor compares it at the falling clk edge inside the due cycle. Frames are run as a dummy frame, a full frame with extra edges and a sample word that changes mid-frame, a short-cycled frame, and a final full frame.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int SLOT_W = 5;

  // strobes from the frame control to the datapath
  typedef struct packed {
    logic              load;   // capture the sample word
    logic              emit;   // frame is open and its data is valid
    logic              drive;  // frame is open
    logic [SLOT_W-1:0] slot;   // serial clock falling edges seen in frame
  } seqStrobe_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int AZ_CLKS    = 3,
  parameter int FRAME_CLKS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  output seqStrobe_t strobe,
  output logic       compPower,
  output logic       autoZero,
  output logic       trackMode,
  output logic       powerOnDone
);
  localparam logic [SLOT_W-1:0] LastSlot  = SLOT_W'(FRAME_CLKS);
  localparam logic [SLOT_W-1:0] DoneSlot  = SLOT_W'(FRAME_CLKS - 1);
  localparam logic [SLOT_W-1:0] AzEndSlot = SLOT_W'(AZ_CLKS);

  logic              csQ, sclkQ, inFrame, dummyFrame, primed;
  logic [SLOT_W-1:0] slotCnt;
  logic              csFall, csRise, sclkFall;

  assign csFall   = csQ & ~csN;
  assign csRise   = ~csQ & csN;
  assign sclkFall = sclkQ & ~sclk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ        <= 1'b1;
      sclkQ      <= 1'b1;
      inFrame    <= 1'b0;
      dummyFrame <= 1'b0;
      primed     <= 1'b0;
      slotCnt    <= '0;
    end else begin
      csQ   <= csN;
      sclkQ <= sclk;
      if (csFall) begin
        inFrame    <= 1'b1;
        dummyFrame <= ~primed;
        slotCnt    <= '0;
      end else if (csN) begin
        inFrame <= 1'b0;
      end else if (inFrame && sclkFall && slotCnt < LastSlot) begin
        slotCnt <= slotCnt + 1'b1;
      end
      if (csRise && inFrame) primed <= 1'b1;
    end
  end

  always_comb begin
    strobe.load  = csFall;
    strobe.drive = inFrame;
    strobe.emit  = inFrame & ~dummyFrame;
    strobe.slot  = slotCnt;
  end

  assign compPower   = inFrame && (slotCnt < DoneSlot);
  assign autoZero    = inFrame && (slotCnt < AzEndSlot);
  assign trackMode   = !inFrame || (slotCnt >= DoneSlot);
  assign powerOnDone = primed;
endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
  import sar_seq_pkg::*;
#(
  parameter int WIDTH   = 12,
  parameter int AZ_CLKS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [WIDTH-1:0] sampleIn,
  output logic             sdoData
);
  localparam int IDX_W     = $clog2(WIDTH);
  localparam int FIRST_OUT = AZ_CLKS + 1;

  logic [WIDTH-1:0] holdReg;
  logic             bitSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdReg <= '0;
    else if (strobe.load) holdReg <= sampleIn;
  end

  always_comb begin
    int rel;
    rel    = int'(strobe.slot) - FIRST_OUT;
    bitSel = 1'b0;
    if (rel >= 0 && rel < WIDTH) bitSel = holdReg[IDX_W'(WIDTH - 1 - rel)];
  end

  assign sdoData = strobe.emit & bitSel;
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int WIDTH      = 12,
  parameter int AZ_CLKS    = 3,
  parameter int FRAME_CLKS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic [WIDTH-1:0] sampleIn,
  output logic             sdoData,
  output logic             sdoDrive,
  output logic             compPower,
  output logic             autoZero,
  output logic             trackMode,
  output logic             powerOnDone
);
  seqStrobe_t strobe;

  sar_seq_ctrl #(.AZ_CLKS(AZ_CLKS), .FRAME_CLKS(FRAME_CLKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .strobe(strobe),
    .compPower(compPower), .autoZero(autoZero), .trackMode(trackMode),
    .powerOnDone(powerOnDone)
  );

  sar_seq_datapath #(.WIDTH(WIDTH), .AZ_CLKS(AZ_CLKS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleIn(sampleIn),
    .sdoData(sdoData)
  );

  assign sdoDrive = strobe.drive;
endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk (
  input logic clk,
  input logic rstN,
  input logic sdoData,
  input logic sdoDrive,
  input logic compPower,
  input logic autoZero,
  input logic trackMode,
  input logic powerOnDone
);
  p_idle_track_r1: assert property (@(posedge clk) disable iff (!rstN)
    !sdoDrive |-> (trackMode && !compPower && !autoZero));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !sdoDrive |-> !sdoData);

  p_az_powered_r4: assert property (@(posedge clk) disable iff (!rstN)
    autoZero |-> compPower);

  p_stay_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sdoDrive && trackMode) |=> !compPower);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    powerOnDone |=> powerOnDone);

  p_set_at_close_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerOnDone) |-> (!sdoDrive && $past(sdoDrive)));
endmodule

bind sar_serial_seq sar_serial_seq_chk chk_i (.*);

// File: tb/sar_serial_seq_tb_top.sv
`timescale 1ns/1ps
module sar_serial_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] sampleIn = '0;
  logic        sdoData, sdoDrive, compPower, autoZero, trackMode, powerOnDone;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  done = 0;

  typedef struct {
    int       due;
    logic [5:0] exp;   // {drive,data,comp,az,track,primed}
    string    tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  sar_serial_seq dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sampleIn(sampleIn),
    .sdoData(sdoData), .sdoDrive(sdoDrive), .compPower(compPower),
    .autoZero(autoZero), .trackMode(trackMode), .powerOnDone(powerOnDone)
  );

  // monitor: compare items in their due cycle
  initial forever begin
    @(negedge clk);
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [5:0] act;
      it  = q.pop_front();
      act = {sdoDrive, sdoData, compPower, autoZero, trackMode, powerOnDone};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s cycle %0d: actual drive/data/comp/az/track/done=%b expected=%b",
                 it.tag, cyc, act, it.exp);
      end
    end
  end

  // driver: set inputs after a rising edge, expect result one cycle later
  task automatic step(input logic c, input logic s, input logic [11:0] smp,
                      input logic [5:0] e, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    csN = c; sclk = s; sampleIn = smp;
    it.due = cyc + 1; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic runFrame(input logic [11:0] smp, input int nClk,
                          input bit dummy, input bit mutate, input bit primedBefore);
    logic [11:0] drv;
    step(1'b0, 1'b1, smp, {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, primedBefore}, "R4");
    drv = mutate ? ~smp : smp;
    for (int k = 1; k <= nClk; k++) begin
      int kk;
      logic d, c, a;
      string tag;
      kk = (k > 16) ? 16 : k;
      c  = kk < 15;
      a  = kk < 3;
      d  = (!dummy && kk >= 4 && kk <= 15) ? smp[15-kk] : 1'b0;
      if (dummy)        tag = "R9";
      else if (k > 16)  tag = "R3";
      else if (mutate)  tag = "R2";
      else if (kk <= 3) tag = "R4";
      else if (kk < 15) tag = "R5";
      else if (kk == 15) tag = "R6";
      else              tag = "R7";
      step(1'b0, 1'b0, drv, {1'b1, d, c, a, !c, primedBefore}, tag);
      step(1'b0, 1'b1, drv, {1'b1, d, c, a, !c, primedBefore}, tag);
    end
    step(1'b1, 1'b1, drv, {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
         (nClk < 16) ? "R8" : "R1");
    step(1'b1, 1'b1, drv, {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, "R1");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // reset state, R1 and R9
    step(1'b1, 1'b1, 12'h000, {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, "R9");
    step(1'b1, 1'b1, 12'hFFF, {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, "R1");
    runFrame(12'hABC, 16, 1'b1, 1'b0, 1'b0);  // dummy frame
    runFrame(12'hA5C, 19, 1'b0, 1'b1, 1'b1);  // full, extra edges, sample changes
    runFrame(12'h3F1, 7,  1'b0, 1'b0, 1'b1);  // short cycled
    runFrame(12'h801, 16, 1'b0, 1'b0, 1'b1);  // full after short cycle
    runFrame(12'h7FE, 16, 1'b0, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule